// File: doc/BRIEF.md
# ALU with function-code control decoder

This block is the execute-stage arithmetic unit of a small load/store processor together with the decoder that selects its operation. The main controller supplies a 2-bit operation class. The instruction supplies a 6-bit function field. From these two inputs the decoder picks a 4-bit operation code. The arithmetic core applies that code to two operands of a parameterised width and returns a result and a flag that is high when the result is all zeros.

Memory instructions use the class that forces an addition, for address generation. Equality branches use the class that forces a subtraction and then test the zero flag. Register-format instructions let the function field choose among AND, OR, add, subtract, signed set-on-less-than and NOR. The unit holds no state and has no clock: every output is a pure function of the present inputs.

Top module: `alu_unit`

## Requirements
- R1: The operation code on `alu_op` uses these values: 4'b0000 AND, 4'b0001 OR, 4'b0010 add, 4'b0110 subtract, 4'b0111 set-on-less-than, 4'b1100 NOR. No other value ever appears.
- R2: With `op_class` = 2'b00, `alu_op` is add (4'b0010) for every `funct` value.
- R3: With `op_class` = 2'b01, `alu_op` is subtract (4'b0110) for every `funct` value.
- R4: With `op_class` = 2'b10, `funct` selects the operation: 6'b100000 add, 6'b100010 subtract, 6'b100100 AND, 6'b100101 OR, 6'b101010 set-on-less-than, 6'b100111 NOR.
- R5: With `op_class` = 2'b10 and any other `funct` value, and with `op_class` = 2'b11 for every `funct` value, `alu_op` is AND (4'b0000).
- R6: `result` gives the bitwise AND, OR or NOR of the operands, or their sum or difference modulo 2^WIDTH, as the operation code selects.
- R7: Set-on-less-than compares the operands as signed two's-complement numbers. It returns 1 in bit 0 when `src_a` < `src_b` and 0 otherwise. All higher bits are zero, including when the difference overflows.
- R8: `zero` is 1 exactly when `result` is all zeros. After a subtract, it is therefore 1 exactly when the operands are equal.
- R9: The block is purely combinational. `alu_op`, `result` and `zero` follow the inputs within the same cycle, with no history from earlier inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 2 | Operation class from the main controller |
| funct | input | 6 | Function field of the instruction |
| src_a | input | WIDTH | First operand |
| src_b | input | WIDTH | Second operand |
| alu_op | output | 4 | Decoded operation code |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
All results are due zero cycles after a stimulus, because nothing is registered. The driver applies a new set of inputs on the falling edge and queues the expected values. The monitor checks them on the following rising edge, half a period later, so every path has settled and no input changes at that moment. Every class and function code is swept against operand pairs chosen for equality, sign mixing and signed overflow.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111,
        OP_NOR = 4'b1100
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_MEM    = 2'b00,
        CLS_BRANCH = 2'b01,
        CLS_REG    = 2'b10,
        CLS_SPARE  = 2'b11
    } op_class_e;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;
    localparam logic [5:0] FN_NOR = 6'b100111;

    // bit positions inside the operation code
    localparam int OPB_INV_A = 3;
    localparam int OPB_NEG_B = 2;

    // low two code bits choose the output path
    localparam logic [1:0] SEL_AND = 2'b00;
    localparam logic [1:0] SEL_OR  = 2'b01;
    localparam logic [1:0] SEL_SUM = 2'b10;
    localparam logic [1:0] SEL_SLT = 2'b11;

endpackage

// File: rtl/alu_ctl_decode.sv
module alu_ctl_decode
    import alu_pkg::*;
(
    input  logic [1:0] op_class,
    input  logic [5:0] funct,
    output logic [3:0] alu_op
);
    alu_op_e op_d;
    alu_op_e fn_op_d;

    always_comb begin
        case (funct)
            FN_ADD:  fn_op_d = OP_ADD;
            FN_SUB:  fn_op_d = OP_SUB;
            FN_AND:  fn_op_d = OP_AND;
            FN_OR:   fn_op_d = OP_OR;
            FN_SLT:  fn_op_d = OP_SLT;
            FN_NOR:  fn_op_d = OP_NOR;
            default: fn_op_d = OP_AND;
        endcase

        case (op_class_e'(op_class))
            CLS_MEM:    op_d = OP_ADD;
            CLS_BRANCH: op_d = OP_SUB;
            CLS_REG:    op_d = fn_op_d;
            default:    op_d = OP_AND;
        endcase
    end

    assign alu_op = op_d;
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] full_d;

    always_comb begin
        full_d = {1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, cin};
        sum    = full_d[MSB:0];
        ovf    = (opnd_a[MSB] == opnd_b[MSB]) && (full_d[MSB] != opnd_a[MSB]);
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       alu_op,
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    output logic [WIDTH-1:0] result,
    output logic             zero
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] a_eff;
        logic [WIDTH-1:0] b_eff;
        logic [WIDTH-1:0] res;
    } core_t;

    core_t            core_d;
    logic [WIDTH-1:0] sum_w;
    logic             ovf_w;
    logic [WIDTH-1:0] a_sel;
    logic [WIDTH-1:0] b_sel;

    generate
        genvar gi;
        for (gi = 0; gi < WIDTH; gi++) begin : g_cond_inv
            assign a_sel[gi] = src_a[gi] ^ alu_op[OPB_INV_A];
            assign b_sel[gi] = src_b[gi] ^ alu_op[OPB_NEG_B];
        end
    endgenerate

    alu_addsub #(.WIDTH(WIDTH)) i_addsub (
        .opnd_a (a_sel),
        .opnd_b (b_sel),
        .cin    (alu_op[OPB_NEG_B]),
        .sum    (sum_w),
        .ovf    (ovf_w)
    );

    always_comb begin
        core_d       = '0;
        core_d.a_eff = a_sel;
        core_d.b_eff = b_sel;
        case (alu_op[1:0])
            SEL_AND: core_d.res = core_d.a_eff & core_d.b_eff;
            SEL_OR:  core_d.res = core_d.a_eff | core_d.b_eff;
            SEL_SUM: core_d.res = sum_w;
            default: core_d.res = {{MSB{1'b0}}, sum_w[MSB] ^ ovf_w};
        endcase
    end

    assign result = core_d.res;
    assign zero   = ~|core_d.res;
endmodule

// File: rtl/alu_unit.sv
module alu_unit #(
    parameter int WIDTH = 32
) (
    input  logic [1:0]       op_class,
    input  logic [5:0]       funct,
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    output logic [3:0]       alu_op,
    output logic [WIDTH-1:0] result,
    output logic             zero
);
    logic [3:0] op_w;

    alu_ctl_decode i_decode (
        .op_class (op_class),
        .funct    (funct),
        .alu_op   (op_w)
    );

    alu_core #(.WIDTH(WIDTH)) i_core (
        .alu_op (op_w),
        .src_a  (src_a),
        .src_b  (src_b),
        .result (result),
        .zero   (zero)
    );

    assign alu_op = op_w;
endmodule

// File: rtl/alu_unit_chk.sv
module alu_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic [1:0]       op_class,
    input logic [5:0]       funct,
    input logic [WIDTH-1:0] src_a,
    input logic [WIDTH-1:0] src_b,
    input logic [3:0]       alu_op,
    input logic [WIDTH-1:0] result,
    input logic             zero
);
    always_comb begin
        // R1
        legal_code_chk: assert final (alu_op inside {4'b0000, 4'b0001, 4'b0010,
                                                     4'b0110, 4'b0111, 4'b1100});
        // R2
        mem_class_add_chk: assert final (op_class != 2'b00 || alu_op == 4'b0010);
        // R3
        branch_class_sub_chk: assert final (op_class != 2'b01 || alu_op == 4'b0110);
        // R5
        spare_class_and_chk: assert final (op_class != 2'b11 || alu_op == 4'b0000);
        // R7
        slt_upper_clear_chk: assert final (alu_op != 4'b0111 || result[WIDTH-1:1] == '0);
        // R8
        branch_equal_chk: assert final (!(op_class == 2'b01) || (zero == (src_a == src_b)));
    end
endmodule

bind alu_unit alu_unit_chk #(.WIDTH(WIDTH)) i_alu_unit_chk (
    .op_class (op_class),
    .funct    (funct),
    .src_a    (src_a),
    .src_b    (src_b),
    .alu_op   (alu_op),
    .result   (result),
    .zero     (zero)
);

// File: tb/test_alu_unit.sv
`timescale 1ns/1ps
module test_alu_unit;
    localparam int W = 32;

    typedef struct {
        logic [1:0]   cls;
        logic [5:0]   fn;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [3:0]   exp_op;
        logic [W-1:0] exp_res;
        logic         exp_zero;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   op_class = '0;
    logic [5:0]   funct = '0;
    logic [W-1:0] src_a = '0;
    logic [W-1:0] src_b = '0;
    logic [3:0]   alu_op;
    logic [W-1:0] result;
    logic         zero;

    item_t q[$];
    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles = 0;
    bit    drive_done = 0;
    bit    finished = 0;

    always #4 clk = ~clk;

    alu_unit #(.WIDTH(W)) i_alu_unit (
        .op_class (op_class),
        .funct    (funct),
        .src_a    (src_a),
        .src_b    (src_b),
        .alu_op   (alu_op),
        .result   (result),
        .zero     (zero)
    );

    // R2 R3 R4 R5 expected code
    function automatic logic [3:0] ref_op(input logic [1:0] c, input logic [5:0] f);
        if (c == 2'b00) return 4'b0010;
        if (c == 2'b01) return 4'b0110;
        if (c == 2'b11) return 4'b0000;
        case (f)
            6'b100000: return 4'b0010;
            6'b100010: return 4'b0110;
            6'b100100: return 4'b0000;
            6'b100101: return 4'b0001;
            6'b101010: return 4'b0111;
            6'b100111: return 4'b1100;
            default:   return 4'b0000;
        endcase
    endfunction

    // R6 R7 expected result
    function automatic logic [W-1:0] ref_res(input logic [3:0] op,
                                             input logic [W-1:0] a, input logic [W-1:0] b);
        case (op)
            4'b0000: return a & b;
            4'b0001: return a | b;
            4'b0010: return a + b;
            4'b0110: return a - b;
            4'b0111: return ($signed(a) < $signed(b)) ? W'(1) : W'(0);
            4'b1100: return ~(a | b);
            default: return 'x;
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp, input item_t it);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: cls=%b fn=%b a=%h b=%h actual=%h expected=%h",
                     req, it.cls, it.fn, it.a, it.b, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] c, input logic [5:0] f,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        item_t it;
        @(negedge clk);
        op_class    = c;
        funct       = f;
        src_a       = a;
        src_b       = b;
        it.cls      = c;
        it.fn       = f;
        it.a        = a;
        it.b        = b;
        it.exp_op   = ref_op(c, f);
        it.exp_res  = ref_res(it.exp_op, a, b);
        it.exp_zero = (it.exp_res == '0);
        q.push_back(it);
    endtask

    // monitor: results are due the same cycle (R9), sampled on the next rising edge
    always @(posedge clk) begin
        if (!rst && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check(it.cls == 2'b00 ? "R2" : it.cls == 2'b01 ? "R3" :
                  it.cls == 2'b11 ? "R5" : "R4 R1", W'(alu_op), W'(it.exp_op), it);
            check(it.exp_op == 4'b0111 ? "R7" : "R6 R9", result, it.exp_res, it);
            check("R8", W'(zero), W'(it.exp_zero), it);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    logic [W-1:0] pa [8];
    logic [W-1:0] pb [8];

    initial begin
        pa[0] = 32'd5;          pb[0] = 32'd3;
        pa[1] = 32'd3;          pb[1] = 32'd5;
        pa[2] = 32'h1234_5678;  pb[2] = 32'h1234_5678;
        pa[3] = 32'hFFFF_FFFE;  pb[3] = 32'd2;
        pa[4] = 32'h8000_0000;  pb[4] = 32'd1;
        pa[5] = 32'h7FFF_FFFF;  pb[5] = 32'hFFFF_FFFF;
        pa[6] = 32'h0F0F_00FF;  pb[6] = 32'hF0F0_0F0F;
        pa[7] = 32'd0;          pb[7] = 32'd0;

        repeat (3) @(posedge clk);
        // reset-time state with all-zero inputs: class 00 add of zeros
        #1;
        n_checks++;
        if (alu_op !== 4'b0010 || result !== '0 || zero !== 1'b1) begin
            n_errors++;
            $display("FAIL R2 R8 idle: actual op=%b res=%h z=%b expected op=0010 res=0 z=1",
                     alu_op, result, zero);
        end
        rst = 1'b0;

        for (int c = 0; c < 4; c++)
            for (int f = 0; f < 64; f++)
                for (int p = 0; p < 8; p++)
                    drive(2'(c), 6'(f), pa[p], pb[p]);

        // R7 signed corner cases, R9 back-to-back changes
        drive(2'b10, 6'b101010, 32'h8000_0000, 32'h7FFF_FFFF);
        drive(2'b10, 6'b101010, 32'h7FFF_FFFF, 32'h8000_0000);
        drive(2'b10, 6'b101010, 32'hFFFF_FFFF, 32'd0);
        drive(2'b10, 6'b101010, 32'd7, 32'd7);
        drive(2'b01, 6'b000000, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
        drive(2'b01, 6'b000000, 32'hDEAD_BEEF, 32'hDEAD_BEEE);
        drive(2'b10, 6'b100111, 32'hFFFF_FFFF, 32'd0);

        @(negedge clk);
        wait (q.size() == 0);
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule